// File: doc/BRIEF.md
# CPU Address Decode Window Bank

This block sits between a CPU bus and a set of downstream targets. It holds a bank of programmable address windows. For every 32-bit address presented on the decode port, it finds the enabled window that covers the address. It reports a hit flag, the index of the selected window, and that window's target ID and attribute. It also produces a translated address. Software configures each window through a simple register port. A register write takes effect at the clock edge that captures it. The decode path is combinational from the current register state.

Each window has a control word and a base address. The control word holds a size mask, a target ID, an attribute and an enable bit. The size mask is a run of ones filled from the LSB, one bit per 64 KiB block. Only the lowest-numbered windows carry remap registers.

A remap-capable window replaces the upper address bits outside the window with the remap-low value. It presents remap-high as the upper half of a 64-bit translated address. When no remapping is wanted, setting remap-low equal to the base gives an identity translation. All other windows pass the address through unchanged. A miss is reported only through the hit flag.

Top module: `awin_decoder`

## Requirements
- R1: After synchronous active-low reset every window is disabled, no address hits, and every register reads back zero.
- R2: A write to a window's control register (select 0) or base register (select 1) is returned on the read port from the next cycle on.
- R3: Only windows 0 and 1 have remap-low (select 2) and remap-high (select 3) registers. For all other windows, writes to those selects are ignored and reads return zero.
- R4: A window hits when its enable bit (control bit 0) is set and address bits [31:16] equal base bits [31:16] wherever the size mask is zero. Address bits [15:0] are never compared, so an all-zero mask gives a 64 KiB window.
- R5: The size mask sits in control bits [31:16]. Each one bit widens the window, so a mask of 0x00FF spans 16 MiB, and base bits under mask ones are ignored.
- R6: Writing a control word with bit 0 clear disables the window from the next cycle, whatever its base.
- R7: When several enabled windows hit, the lowest-numbered window is reported. Two windows may share a base and target, and the result stays stable.
- R8: On a hit, the target ID output is control bits [7:4] of the selected window and the attribute output is control bits [15:8]. The window index output is also given.
- R9: For a remap-capable window, translated bits [31:16] take remap-low bits where the mask is zero and address bits where it is one. Bits [15:0] copy the address, and the upper translated word equals remap-high.
- R10: A hit in a window without remap, or a miss, gives a translated low word equal to the address and an upper word of zero. A miss also gives zero target and attribute.
- R11: A decode in the same cycle as a register write uses the configuration held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window index for write and read |
| cfg_reg | input | 2 | Register select: 0 control, 1 base, 2 remap-low, 3 remap-high |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| dec_addr | input | 32 | Address to decode |
| dec_hit | output | 1 | Some enabled window covers the address |
| dec_win | output | 3 | Index of the winning window |
| dec_tgt | output | 4 | Target ID of the winning window |
| dec_attr | output | 8 | Target attribute of the winning window |
| dec_xlat_lo | output | 32 | Translated address, low word |
| dec_xlat_hi | output | 32 | Translated address, high word |

## Verification
A register write and a decode can fall in the same cycle. The most critical case is a control write that disables the very window the address currently hits. The bench provokes this with a directed case. It drives the disabling write and a covered address together and checks before the edge that the old window still wins. After the edge it expects the lower-priority window or a miss. The random phase mixes writes and decodes to shared base regions, so overlap and priority resolution against a reference model in the bench are exercised repeatedly.

// File: rtl/awin_pkg.sv
// Shared types and constants for the address decode window bank.
// Assumes a 32-bit address space decoded in 64 KiB blocks.
package awin_pkg;
    localparam int ADDR_W = 32;
    localparam int BLK_W  = 16;               // bits below the block granule
    localparam int HI_W   = ADDR_W - BLK_W;   // compared address bits

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BASE = 2'd1,
        REG_RLO  = 2'd2,
        REG_RHI  = 2'd3
    } awin_reg_e;

    // Control word layout: [31:16] size mask, [15:8] attribute,
    // [7:4] target, [3:1] spare, [0] enable.
    typedef struct packed {
        logic [HI_W-1:0] size_mask;
        logic [7:0]      attr;
        logic [3:0]      tgt;
        logic [2:0]      spare;
        logic            en;
    } awin_ctrl_t;
endpackage

// File: rtl/awin_regs.sv
// Register set of one decode window: control, base and (optionally)
// remap-low/high. Assumes wr_en is already qualified by window index.
module awin_regs
    import awin_pkg::*;
#(
    parameter bit HAS_REMAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_reg,
    input  logic [ADDR_W-1:0] wdata,
    output awin_ctrl_t        ctrl_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] rlo_q,
    output logic [ADDR_W-1:0] rhi_q
);
    // Capture control and base writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
        end else if (wr_en) begin
            if (awin_reg_e'(wr_reg) == REG_CTRL) ctrl_q <= awin_ctrl_t'(wdata);
            if (awin_reg_e'(wr_reg) == REG_BASE) base_q <= wdata;
        end
    end

    generate
        if (HAS_REMAP) begin : g_remap
            // Capture remap writes for remap-capable windows.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rlo_q <= '0;
                    rhi_q <= '0;
                end else if (wr_en) begin
                    if (awin_reg_e'(wr_reg) == REG_RLO) rlo_q <= wdata;
                    if (awin_reg_e'(wr_reg) == REG_RHI) rhi_q <= wdata;
                end
            end
        end else begin : g_noremap
            assign rlo_q = '0;
            assign rhi_q = '0;
        end
    endgenerate
endmodule

// File: rtl/awin_match.sv
// Hit test and address translation for one window. Assumes the size
// mask is a thermometer code; any mask is applied bit by bit.
module awin_match
    import awin_pkg::*;
#(
    parameter bit HAS_REMAP = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [HI_W-1:0]   mask,
    input  logic [HI_W-1:0]   base_hi,
    input  logic [HI_W-1:0]   rlo_hi,
    input  logic [ADDR_W-1:0] rhi,
    output logic              hit,
    output logic [ADDR_W-1:0] xlat_lo,
    output logic [ADDR_W-1:0] xlat_hi
);
    logic [HI_W-1:0] diff;

    // Compare upper address bits outside the mask.
    always_comb begin
        diff = (addr[ADDR_W-1:BLK_W] ^ base_hi) & ~mask;
        hit  = en && (diff == '0);
    end

    // Form the translated address.
    always_comb begin
        if (HAS_REMAP) begin
            xlat_lo = {(rlo_hi & ~mask) | (addr[ADDR_W-1:BLK_W] & mask),
                       addr[BLK_W-1:0]};
            xlat_hi = rhi;
        end else begin
            xlat_lo = addr;
            xlat_hi = '0;
        end
    end
endmodule

// File: rtl/awin_prio.sv
// Selects the lowest-numbered hitting window and forwards its fields.
// Assumes per-window translations are already computed.
module awin_prio
    import awin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_WIN-1:0]              hit_vec,
    input  awin_ctrl_t [NUM_WIN-1:0]        ctrl,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xlo,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xhi,
    output logic                            hit,
    output logic [IDX_W-1:0]                win,
    output logic [3:0]                      tgt,
    output logic [7:0]                      attr,
    output logic [ADDR_W-1:0]               xlat_lo,
    output logic [ADDR_W-1:0]               xlat_hi
);
    // Scan high to low so the lowest index is assigned last and wins.
    always_comb begin
        hit     = 1'b0;
        win     = '0;
        tgt     = '0;
        attr    = '0;
        xlat_lo = addr;
        xlat_hi = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                win     = IDX_W'(i);
                tgt     = ctrl[i].tgt;
                attr    = ctrl[i].attr;
                xlat_lo = xlo[i];
                xlat_hi = xhi[i];
            end
        end
    end
endmodule

// File: rtl/awin_decoder.sv
// Top of the address decode window bank: register port, per-window
// registers and match logic, and priority select. Decode is
// combinational from registered configuration.
module awin_decoder
    import awin_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_win,
    input  logic [1:0]        cfg_reg,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       dec_addr,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_win,
    output logic [3:0]        dec_tgt,
    output logic [7:0]        dec_attr,
    output logic [31:0]       dec_xlat_lo,
    output logic [31:0]       dec_xlat_hi
);
    awin_ctrl_t [NUM_WIN-1:0]       ctrl_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] rlo_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] rhi_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xlo;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xhi;
    logic [NUM_WIN-1:0]             hit_vec;

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            localparam bit HAS_RM = (g < NUM_REMAP);
            logic wr_this;
            assign wr_this = cfg_wr && (cfg_win == IDX_W'(g));

            awin_regs #(.HAS_REMAP(HAS_RM)) u_regs (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_this),
                .wr_reg (cfg_reg),
                .wdata  (cfg_wdata),
                .ctrl_q (ctrl_q[g]),
                .base_q (base_q[g]),
                .rlo_q  (rlo_q[g]),
                .rhi_q  (rhi_q[g])
            );

            awin_match #(.HAS_REMAP(HAS_RM)) u_match (
                .addr    (dec_addr),
                .en      (ctrl_q[g].en),
                .mask    (ctrl_q[g].size_mask),
                .base_hi (base_q[g][ADDR_W-1:BLK_W]),
                .rlo_hi  (rlo_q[g][ADDR_W-1:BLK_W]),
                .rhi     (rhi_q[g]),
                .hit     (hit_vec[g]),
                .xlat_lo (xlo[g]),
                .xlat_hi (xhi[g])
            );
        end
    endgenerate

    awin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .addr    (dec_addr),
        .hit_vec (hit_vec),
        .ctrl    (ctrl_q),
        .xlo     (xlo),
        .xhi     (xhi),
        .hit     (dec_hit),
        .win     (dec_win),
        .tgt     (dec_tgt),
        .attr    (dec_attr),
        .xlat_lo (dec_xlat_lo),
        .xlat_hi (dec_xlat_hi)
    );

    // Read mux for the selected window register.
    always_comb begin
        unique case (awin_reg_e'(cfg_reg))
            REG_CTRL: cfg_rdata = ctrl_q[cfg_win];
            REG_BASE: cfg_rdata = base_q[cfg_win];
            REG_RLO:  cfg_rdata = rlo_q[cfg_win];
            REG_RHI:  cfg_rdata = rhi_q[cfg_win];
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/awin_decoder_chk.sv
// Assertion checker for awin_decoder, attached by bind below.
module awin_decoder_chk #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [IDX_W-1:0]  cfg_win,
    input logic [1:0]        cfg_reg,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic [31:0]       dec_addr,
    input logic              dec_hit,
    input logic [IDX_W-1:0]  dec_win,
    input logic [3:0]        dec_tgt,
    input logic [7:0]        dec_attr,
    input logic [31:0]       dec_xlat_lo,
    input logic [31:0]       dec_xlat_hi
);
    // R1: first cycle out of reset has no hit
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !dec_hit);

    // R2: written control/base value is read back next cycle
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_reg[1] == 1'b0) |=>
        ((cfg_win == $past(cfg_win) && cfg_reg == $past(cfg_reg)) ->
         cfg_rdata == $past(cfg_wdata)));

    // R3: absent remap registers read as zero
    p_no_remap_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reg[1] && int'(cfg_win) >= NUM_REMAP) |-> cfg_rdata == 32'd0);

    // R6: disabling write removes that window from the next cycle
    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_reg == 2'd0 && !cfg_wdata[0]) |=>
        !(dec_hit && dec_win == $past(cfg_win)));

    // R9: the in-block offset is always passed through
    p_offset_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_xlat_lo[15:0] == dec_addr[15:0]);

    // R10: a miss carries a clean, untranslated result
    p_miss_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_tgt == 4'd0 && dec_attr == 8'd0 &&
                      dec_xlat_lo == dec_addr && dec_xlat_hi == 32'd0));

    // R10: a hit in a window without remap leaves the address unchanged
    p_plain_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && int'(dec_win) >= NUM_REMAP) |->
        (dec_xlat_lo == dec_addr && dec_xlat_hi == 32'd0));
endmodule

bind awin_decoder awin_decoder_chk #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_chk (.*);

// File: tb/tb_awin_decoder.sv
module tb_awin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] dec_addr = '0;
    logic        dec_hit;
    logic [2:0]  dec_win;
    logic [3:0]  dec_tgt;
    logic [7:0]  dec_attr;
    logic [31:0] dec_xlat_lo, dec_xlat_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl [8];
    logic [31:0] m_base [8];
    logic [31:0] m_rlo  [2];
    logic [31:0] m_rhi  [2];

    always #2 clk = ~clk;   // 250 MHz

    awin_decoder dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(logic [15:0] mask, logic [7:0] attr,
                                            logic [3:0] tgt, logic en);
        return {mask, attr, tgt, 3'b000, en};
    endfunction

    // Reference read of a register
    function automatic logic [31:0] exp_rd(int w, int r);
        case (r)
            0: return m_ctrl[w];
            1: return m_base[w];
            2: return (w < 2) ? m_rlo[w] : 32'd0;
            default: return (w < 2) ? m_rhi[w] : 32'd0;
        endcase
    endfunction

    task automatic wr(int w, int r, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_win = w[2:0]; cfg_reg = r[1:0]; cfg_wdata = d;
        @(posedge clk);
        if (r == 0) m_ctrl[w] = d;
        else if (r == 1) m_base[w] = d;
        else if (w < 2 && r == 2) m_rlo[w] = d;
        else if (w < 2) m_rhi[w] = d;
        #1 cfg_wr = 1'b0;
    endtask

    task automatic rd(int w, int r, string req);
        @(negedge clk);
        cfg_win = w[2:0]; cfg_reg = r[1:0];
        #1 chk(req, cfg_rdata, exp_rd(w, r));
    endtask

    // Compare decode outputs with the reference model, no clock wait
    task automatic dcmp(string req);
        logic h; logic [2:0] wi; logic [3:0] t; logic [7:0] at;
        logic [31:0] xl, xh, m, c;
        h = 0; wi = 0; t = 0; at = 0; xl = dec_addr; xh = 0;
        for (int i = 7; i >= 0; i--) begin
            c = m_ctrl[i];
            m = {16'h0, c[31:16]};
            if (c[0] && (((dec_addr[31:16] ^ m_base[i][31:16]) & ~m[15:0]) == 16'h0)) begin
                h = 1; wi = i[2:0]; t = c[7:4]; at = c[15:8];
                if (i < 2) begin
                    xl = {(m_rlo[i][31:16] & ~m[15:0]) | (dec_addr[31:16] & m[15:0]),
                          dec_addr[15:0]};
                    xh = m_rhi[i];
                end else begin
                    xl = dec_addr; xh = 0;
                end
            end
        end
        chk({req, " hit"},  {31'd0, dec_hit}, {31'd0, h});
        chk({req, " win"},  {29'd0, dec_win}, {29'd0, wi});
        chk({req, " tgt"},  {28'd0, dec_tgt}, {28'd0, t});
        chk({req, " attr"}, {24'd0, dec_attr}, {24'd0, at});
        chk({req, " xlo"},  dec_xlat_lo, xl);
        chk({req, " xhi"},  dec_xlat_hi, xh);
    endtask

    task automatic dchk(logic [31:0] a, string req);
        @(negedge clk);
        dec_addr = a;
        #1 dcmp(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 8; i++) begin m_ctrl[i] = 0; m_base[i] = 0; end
        for (int i = 0; i < 2; i++) begin m_rlo[i] = 0; m_rhi[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        dchk(32'h0000_0000, "R1");
        dchk(32'hDEAD_BEEF, "R1");
        rd(3, 0, "R1 ctrl");
        rd(0, 2, "R1 remap");

        // R4 R8: smallest window with fields
        wr(2, 1, 32'h1234_0000);
        wr(2, 0, mk_ctrl(16'h0000, 8'h5A, 4'h3, 1'b1));
        rd(2, 0, "R2 ctrl");
        rd(2, 1, "R2 base");
        dchk(32'h1234_ABCD, "R4 R8 inside");
        dchk(32'h1235_0000, "R4 past end");
        dchk(32'h1233_FFFF, "R4 before");

        // R5: 16 MiB window, base bits under mask ignored
        wr(4, 1, 32'h4055_0000);
        wr(4, 0, mk_ctrl(16'h00FF, 8'hC1, 4'h9, 1'b1));
        dchk(32'h4000_0000, "R5 low edge");
        dchk(32'h40FF_FFFF, "R5 high edge");
        dchk(32'h4100_0000, "R5 outside");

        // R9: remap window 0
        wr(0, 1, 32'h8000_0000);
        wr(0, 2, 32'h1230_0000);
        wr(0, 3, 32'h0000_0007);
        wr(0, 0, mk_ctrl(16'h000F, 8'h11, 4'h1, 1'b1));
        rd(0, 2, "R3 rlo");
        rd(0, 3, "R3 rhi");
        dchk(32'h800A_1234, "R9 remap");

        // R3 R10: remap writes to a plain window ignored
        wr(5, 2, 32'hFFFF_FFFF);
        wr(5, 3, 32'hFFFF_FFFF);
        rd(5, 2, "R3 ignored rlo");
        rd(5, 3, "R3 ignored rhi");
        wr(5, 1, 32'h2000_0000);
        wr(5, 0, mk_ctrl(16'h0003, 8'h22, 4'h5, 1'b1));
        dchk(32'h2002_0004, "R10 plain");

        // R7: shared base on windows 1 and 6, identity remap on 1
        wr(1, 1, 32'h6000_0000);
        wr(1, 2, 32'h6000_0000);
        wr(1, 0, mk_ctrl(16'h0001, 8'h33, 4'h7, 1'b1));
        wr(6, 1, 32'h6000_0000);
        wr(6, 0, mk_ctrl(16'h0001, 8'h33, 4'h7, 1'b1));
        dchk(32'h6001_0040, "R7 lowest wins");
        chk("R9 identity", dec_xlat_lo, 32'h6001_0040);

        // R6: zero control disables window 1, window 6 takes over
        wr(1, 0, 32'h0);
        dchk(32'h6001_0040, "R6 disabled");

        // R11: disable window 6 with a decode in the same cycle
        @(negedge clk);
        dec_addr = 32'h6000_1111;
        cfg_wr = 1'b1; cfg_win = 3'd6; cfg_reg = 2'd0; cfg_wdata = 32'h0;
        #1 dcmp("R11 before edge");
        @(posedge clk);
        m_ctrl[6] = 32'h0;
        #1 cfg_wr = 1'b0;
        dcmp("R11 after edge");
        dchk(32'h6000_1111, "R6 R11 miss");

        // Random mix of writes, reads and decodes
        for (int n = 0; n < 600; n++) begin
            int act;
            int w;
            act = $urandom_range(0, 9);
            w = $urandom_range(0, 7);
            if (act < 3) begin
                int len;
                logic [15:0] mk;
                len = $urandom_range(0, 16);
                mk = (len == 0) ? 16'h0 : 16'(32'hFFFF >> (16 - len));
                wr(w, 0, mk_ctrl(mk, 8'($urandom), 4'($urandom), 1'($urandom_range(0, 3) != 0)));
            end else if (act < 5) begin
                int r;
                r = $urandom_range(1, 3);
                wr(w, r, {4'h0, 4'($urandom_range(0, 3)), 8'($urandom_range(0, 255)) & 8'hF0,
                          16'($urandom)});
            end else if (act < 6) begin
                rd(w, $urandom_range(0, 3), "R2 R3 random read");
            end else begin
                dchk({4'h0, 4'($urandom_range(0, 3)), 8'($urandom), 16'($urandom)},
                     "R4 R5 R7 R9 R10 random");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule